// File: doc/BRIEF.md
# Sector Buffer Address Down-Counter

This block produces the RAM address for a 1024-byte sector buffer in a disk controller. The processor in that controller can only reach the buffer through I/O port accesses, so it cannot address memory itself. Firmware writes a start address over an 8-bit I/O bus through two write ports. The low port sets the eight low address bits. The high port sets the two top bits. Each write replaces only its own field.

Every RAM access ends with a one-cycle access strobe. The address is decremented on the clock edge that ends that strobe, so it stays stable for the whole access that uses it. The counter is built from cascaded stages linked by a borrow signal. A stage steps down only when every stage below it is at zero during an access.

The borrow out of the top stage drives an active-low end-of-loop flag, which the processor reads on bit 0 of a status port. A start value of L pulls the flag low when the access at address 0 completes, which is access number L+1. Firmware picks the start value to set a loop length from 1 to 1024 accesses, such as the common 128, 256 and 512 byte sectors.

Top module: `sbuf_addr_dncnt`

## Requirements
- R1: A synchronous reset sets the address to 0 and the end flag `end_n` to 1 (inactive).
- R2: A pulse on `wr_lo` loads `io_wdata[7:0]` into address bits 7:0 and leaves bits 9:8 unchanged.
- R3: A pulse on `wr_hi` loads `io_wdata[1:0]` into address bits 9:8. It leaves bits 7:0 unchanged, and data bits 7:2 have no effect.
- R4: When `acc_strobe` is high and no write is present, the address drops by one on that clock edge. With no strobe and no write, the address holds.
- R5: A decrement that crosses a stage boundary borrows correctly, for example 0x100 becomes 0x0FF and 0x010 becomes 0x00F.
- R6: After a start value L is loaded, `end_n` stays 1 for the first L strobes and becomes 0 on the edge of strobe L+1, the access at address 0.
- R7: A strobe at address 0 wraps the address to 1023 and drives `end_n` low. `end_n` then stays low through further strobes until the next write.
- R8: Any write, to either port, sets `end_n` back to 1 on that edge.
- R9: When a write and `acc_strobe` arrive in the same cycle, the write takes effect and no decrement happens.
- R10: While `rd_status` is high, `status_data` has `end_n` in bit 0 and zeros in bits 7:1. While it is low, `status_data` is all zeros. Reading never changes the address or the flag.
- R11: Start values 127, 255 and 511 give loops of exactly 128, 256 and 512 strobes before `end_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| io_wdata | input | 8 | I/O bus write data |
| wr_lo | input | 1 | Write strobe for address bits 7:0 |
| wr_hi | input | 1 | Write strobe for address bits 9:8 |
| acc_strobe | input | 1 | One-cycle pulse that ends a RAM access |
| rd_status | input | 1 | Status port read enable |
| ram_addr | output | 10 | Buffer RAM address |
| status_data | output | 8 | Status port read data, flag in bit 0 |
| end_n | output | 1 | Active-low end-of-loop flag |

## Verification
The hardest states to reach from the ports are the full-length loops and the wrap past zero. Random traffic almost never makes 512 or 1024 strokes in a row without also rewriting the address. Directed runs therefore load each start value through both ports and then strobe exactly the loop length. The bench checks that the flag is still high one strobe before the end and low at the end, and then strobes past the wrap. Constrained random traffic, which mixes writes, strobes and overlapping write-plus-strobe cycles, covers the stage borrows and the write priority.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;

   function automatic int stage_count(input int addr_w, input int stage_w);
      return (addr_w + stage_w - 1) / stage_w;
   endfunction

   function automatic int stage_width(input int addr_w, input int stage_w, input int idx);
      int rem;
      rem = addr_w - idx * stage_w;
      return (rem < stage_w) ? rem : stage_w;
   endfunction

endpackage

// File: rtl/sbuf_load_map.sv
module sbuf_load_map #(
   parameter int ADDR_W = 10,
   parameter int BUS_W  = 8
) (
   input  logic [BUS_W-1:0]  wdata,
   input  logic              wr_lo,
   input  logic              wr_hi,
   output logic [ADDR_W-1:0] ld_mask,
   output logic [ADDR_W-1:0] ld_data,
   output logic              any_load
);

   for (genvar k = 0; k < ADDR_W; k++) begin : g_bit
      if (k < BUS_W) begin : g_low
         assign ld_mask[k] = wr_lo;
         assign ld_data[k] = wdata[k];
      end else begin : g_high
         assign ld_mask[k] = wr_hi;
         assign ld_data[k] = wdata[k-BUS_W];
      end
   end

   assign any_load = wr_lo | wr_hi;

endmodule

// File: rtl/sbuf_stage.sv
module sbuf_stage #(
   parameter int W = 4
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         any_load,
   input  logic [W-1:0] ld_mask,
   input  logic [W-1:0] ld_data,
   input  logic         bin,
   output logic [W-1:0] q,
   output logic         bout
);

   logic [W-1:0] q_nxt;

   always_comb begin
      q_nxt = q;
      if (any_load)
         q_nxt = (q & ~ld_mask) | (ld_data & ld_mask);
      else if (bin)
         q_nxt = q - W'(1);
   end

   always_ff @(posedge clk) begin
      if (rst) q <= '0;
      else     q <= q_nxt;
   end

   assign bout = bin & (q == '0);

   // R5
   stage_wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (bin && !any_load && q == '0) |=> (q == {W{1'b1}}));

endmodule

// File: rtl/sbuf_flag.sv
module sbuf_flag (
   input  logic clk,
   input  logic rst,
   input  logic any_load,
   input  logic term_borrow,
   output logic end_n
);

   always_ff @(posedge clk) begin
      if (rst)              end_n <= 1'b1;
      else if (any_load)    end_n <= 1'b1;
      else if (term_borrow) end_n <= 1'b0;
   end

   // R7
   flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!end_n && !any_load) |=> !end_n);

endmodule

// File: rtl/sbuf_addr_dncnt.sv
module sbuf_addr_dncnt #(
   parameter int ADDR_W  = 10,
   parameter int BUS_W   = 8,
   parameter int STAGE_W = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [BUS_W-1:0]  io_wdata,
   input  logic              wr_lo,
   input  logic              wr_hi,
   input  logic              acc_strobe,
   input  logic              rd_status,
   output logic [ADDR_W-1:0] ram_addr,
   output logic [BUS_W-1:0]  status_data,
   output logic              end_n
);
   import sbuf_pkg::*;

   localparam int NSTAGE = stage_count(ADDR_W, STAGE_W);

   if (ADDR_W <= BUS_W || ADDR_W > 2 * BUS_W) begin : g_bad_addr_w
      $error("ADDR_W must exceed BUS_W and fit in two bus writes");
   end
   if (STAGE_W < 1 || STAGE_W > ADDR_W) begin : g_bad_stage_w
      $error("STAGE_W must lie between 1 and ADDR_W");
   end

   logic [ADDR_W-1:0] ld_mask, ld_data;
   logic              any_load;
   logic [NSTAGE:0]   borrow;

   sbuf_load_map #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_map (
      .wdata(io_wdata), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .ld_mask(ld_mask), .ld_data(ld_data), .any_load(any_load)
   );

   assign borrow[0] = acc_strobe & ~any_load;

   for (genvar i = 0; i < NSTAGE; i++) begin : g_stage
      localparam int SW  = stage_width(ADDR_W, STAGE_W, i);
      localparam int LSB = i * STAGE_W;
      sbuf_stage #(.W(SW)) u_stage (
         .clk(clk), .rst(rst), .any_load(any_load),
         .ld_mask(ld_mask[LSB +: SW]), .ld_data(ld_data[LSB +: SW]),
         .bin(borrow[i]), .q(ram_addr[LSB +: SW]), .bout(borrow[i+1])
      );
   end

   sbuf_flag u_flag (
      .clk(clk), .rst(rst), .any_load(any_load),
      .term_borrow(borrow[NSTAGE]), .end_n(end_n)
   );

   assign status_data = rd_status ? {{(BUS_W-1){1'b0}}, end_n} : '0;

   // R1
   reset_state_chk: assert property (@(posedge clk)
      rst |=> (ram_addr == '0 && end_n));

   // R4
   post_dec_chk: assert property (@(posedge clk) disable iff (rst)
      (acc_strobe && !wr_lo && !wr_hi && ram_addr != '0)
      |=> (ram_addr == $past(ram_addr) - ADDR_W'(1)) && $stable(end_n));

   // R4
   addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!acc_strobe && !wr_lo && !wr_hi) |=> ($stable(ram_addr) && $stable(end_n)));

   // R7
   wrap_chk: assert property (@(posedge clk) disable iff (rst)
      (acc_strobe && !wr_lo && !wr_hi && ram_addr == '0)
      |=> (ram_addr == {ADDR_W{1'b1}} && !end_n));

   // R8
   load_clears_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_lo || wr_hi) |=> end_n);

   // R9
   load_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_lo && acc_strobe) |=> (ram_addr[BUS_W-1:0] == $past(io_wdata)));

   // R10
   status_fmt_chk: assert property (@(posedge clk) disable iff (rst)
      rd_status |-> (status_data == {{(BUS_W-1){1'b0}}, end_n}));

endmodule

// File: tb/sbuf_addr_dncnt_tb.sv
module sbuf_addr_dncnt_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic [7:0] io_wdata;
   logic       wr_lo, wr_hi, acc_strobe, rd_status;
   logic [9:0] ram_addr;
   logic [7:0] status_data;
   logic       end_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   logic [9:0] e_addr;
   logic       e_n;

   always #5 clk = ~clk;

   sbuf_addr_dncnt dut_i (
      .clk(clk), .rst(rst), .io_wdata(io_wdata), .wr_lo(wr_lo), .wr_hi(wr_hi),
      .acc_strobe(acc_strobe), .rd_status(rd_status), .ram_addr(ram_addr),
      .status_data(status_data), .end_n(end_n)
   );

   function automatic logic [7:0] exp_status(input logic rd, input logic n);
      return rd ? {7'b0, n} : 8'h00;
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   task automatic model(input bit wl, input bit wh, input bit acc, input logic [7:0] d);
      if (wl) e_addr[7:0] = d;
      if (wh) e_addr[9:8] = d[1:0];
      if (wl || wh) e_n = 1'b1;
      else if (acc) begin
         if (e_addr == 10'd0) begin e_n = 1'b0; e_addr = 10'h3FF; end
         else e_addr = e_addr - 10'd1;
      end
   endtask

   // one cycle, starting and ending at a falling edge
   task automatic cyc(input bit wl, input bit wh, input bit acc, input bit rd,
                      input logic [7:0] d, input string req);
      wr_lo = wl; wr_hi = wh; acc_strobe = acc; rd_status = rd; io_wdata = d;
      #1;
      chk(status_data == exp_status(rd, e_n), "R10", status_data, exp_status(rd, e_n));
      model(wl, wh, acc, d);
      @(negedge clk);
      wr_lo = 0; wr_hi = 0; acc_strobe = 0; rd_status = 0;
      chk(ram_addr == e_addr, req, ram_addr, e_addr);
      chk(end_n == e_n, req, end_n, e_n);
   endtask

   task automatic load(input logic [9:0] v);
      cyc(0, 1, 0, 0, {6'b101010, v[9:8]}, "R3");
      cyc(1, 0, 0, 0, v[7:0], "R2");
   endtask

   task automatic run_len(input int len, input string req);
      load(10'(len - 1));
      for (int i = 0; i < len - 1; i++) cyc(0, 0, 1, 0, 8'h00, req);
      chk(end_n == 1'b1, req, end_n, 1);
      cyc(0, 0, 1, 1, 8'h00, req);
      chk(end_n == 1'b0 && ram_addr == 10'h3FF, req, {ram_addr, end_n}, {10'h3FF, 1'b0});
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd12345;
      void'($urandom(seed));
      rst = 1; wr_lo = 0; wr_hi = 0; acc_strobe = 0; rd_status = 0; io_wdata = 0;
      repeat (3) @(negedge clk);
      rst = 0;
      e_addr = 0; e_n = 1;
      // R1 reset state
      chk(ram_addr == 10'd0, "R1", ram_addr, 0);
      chk(end_n == 1'b1, "R1", end_n, 1);

      // R2 / R3 field isolation
      cyc(0, 1, 0, 0, 8'hFE, "R3");
      chk(ram_addr == 10'h200, "R3", ram_addr, 10'h200);
      cyc(1, 0, 0, 0, 8'h5A, "R2");
      chk(ram_addr == 10'h25A, "R2", ram_addr, 10'h25A);
      cyc(0, 1, 0, 0, 8'hFD, "R3");
      chk(ram_addr == 10'h15A, "R3", ram_addr, 10'h15A);
      cyc(0, 0, 0, 1, 8'h00, "R4");

      // R5 stage borrows
      load(10'h100);
      cyc(0, 0, 1, 0, 8'h00, "R5");
      chk(ram_addr == 10'h0FF, "R5", ram_addr, 10'h0FF);
      load(10'h010);
      cyc(0, 0, 1, 0, 8'h00, "R5");
      chk(ram_addr == 10'h00F, "R5", ram_addr, 10'h00F);

      // R9 write wins over strobe
      cyc(1, 0, 1, 0, 8'h33, "R9");
      chk(ram_addr == 10'h033, "R9", ram_addr, 10'h033);

      // R6 / R11 loop lengths
      run_len(1, "R6");
      run_len(128, "R11");
      run_len(256, "R11");
      run_len(512, "R11");
      run_len(1024, "R6");

      // R7 flag persists past wrap, R10 read has no effect
      cyc(0, 0, 1, 1, 8'h00, "R7");
      chk(ram_addr == 10'h3FE && end_n == 1'b0, "R7", {ram_addr, end_n}, {10'h3FE, 1'b0});
      cyc(0, 0, 0, 1, 8'h00, "R10");
      chk(ram_addr == 10'h3FE && end_n == 1'b0, "R10", {ram_addr, end_n}, {10'h3FE, 1'b0});
      // R8 write restores flag
      cyc(0, 1, 0, 0, 8'h00, "R8");
      chk(end_n == 1'b1, "R8", end_n, 1);

      // random traffic with small loads so wraps occur
      for (int n = 0; n < 4000; n++) begin
         int unsigned r;
         r = $urandom_range(0, 99);
         if (r < 4)       cyc(1, 0, $urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom_range(0, 20)), "R2");
         else if (r < 7)  cyc(0, 1, $urandom_range(0, 1), $urandom_range(0, 1), 8'($urandom), "R3");
         else if (r < 9)  cyc(1, 1, 1, $urandom_range(0, 1), 8'($urandom), "R9");
         else if (r < 75) cyc(0, 0, 1, $urandom_range(0, 1), 8'($urandom), "R4");
         else             cyc(0, 0, 0, $urandom_range(0, 1), 8'($urandom), "R10");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule